// File: doc/BRIEF.md
# Line Status and Interrupt Controller

This block gathers the status of a line interface and turns it into one maskable interrupt request. Three sources feed it. Two are real-time condition levels: a transmit open-circuit flag and a transmit current-limit flag. The third is a jitter-buffer limit-trip event. A condition level is sampled every clock. Any change of a condition, whether it rises or falls, marks that source as pending. A trip event marks its source as pending and also latches a sticky status bit.

Software reaches the block through a plain register port with two addresses. A read of the status address returns the sampled condition levels and the latched trip bit, and it clears every pending source. The mask address holds one enable bit for each source and can be read back freely. The interrupt output is high while any pending source has its mask bit set. Only the interrupt logic is modelled here; the analog detectors that produce the condition levels lie outside the block.

Top module: `line_stat_irq`

## Requirements
- R1: After reset the status read returns 0x00, the mask read returns 0x00 and `irq` is low.
- R2: A status read (address 0) returns the open-circuit level sampled at the previous clock edge on bit 1, the current-limit level on bit 2 and the latched trip bit on bit 4. Every other bit reads 0.
- R3: A write to the mask address (address 1) stores data bits 1, 2 and 4 as enables for open-circuit, current-limit and trip. A mask read returns those bits in the same positions, with all other bits 0. A write to the status address leaves the mask unchanged.
- R4: A rising edge on a condition input marks that source pending at the next clock edge. A condition held steady marks nothing.
- R5: A falling edge on a condition input also marks that source pending at the next clock edge.
- R6: A cycle with `trip_evt` high sets the trip status bit and marks trip pending at the next edge. The bit stays set until a status read, and that read clears it.
- R7: A status read clears every pending source at the end of the read cycle, so `irq` falls one edge later unless a new source becomes pending.
- R8: A trip event or condition edge in the same cycle as a status read stays pending after that read.
- R9: `irq` is high exactly when some pending source has its mask bit at 1. Sources are marked pending whether or not they are masked, so setting a mask bit later raises `irq` at once, and clearing it lowers `irq`.
- R10: A read of the mask address clears no pending source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| open_det | input | 1 | Transmit open-circuit condition level |
| ilim_det | input | 1 | Transmit current-limit condition level |
| trip_evt | input | 1 | Jitter-buffer limit-trip event, one flag per cycle |
| bus_addr | input | ADDR_W | Register select: 0 status, 1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the status address clears pending sources |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address during a read, 0 otherwise |
| irq | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational, so the monitor samples it at the falling edge in the middle of the read cycle. It sees the value from before the read clears anything. A condition change, a trip pulse or a mask write is applied just after a rising edge and takes effect at the next one. The bench therefore checks `irq` right after that single edge, and after the edge that ends a read, since one register stage lies between each stimulus and its result. Expected status bytes follow the fixed bit positions of the requirements and the input levels the bench last drove.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NSRC     = 3;
    localparam int unsigned NCOND    = 2;
    localparam int unsigned SRC_OPEN = 0;
    localparam int unsigned SRC_ILIM = 1;
    localparam int unsigned SRC_TRIP = 2;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic stat_rd;
        logic mask_rd;
        logic mask_wr;
    } acc_t;

    // register bit position of each source
    function automatic int unsigned src_pos(int unsigned s);
        case (s)
            SRC_OPEN: return 1;
            SRC_ILIM: return 2;
            default:  return 4;
        endcase
    endfunction

    function automatic byte_t place(src_vec_t v);
        byte_t b;
        b = '0;
        for (int unsigned i = 0; i < NSRC; i++) begin
            b[src_pos(i)] = v[i];
        end
        return b;
    endfunction

    function automatic src_vec_t pick(byte_t b);
        src_vec_t v;
        for (int unsigned i = 0; i < NSRC; i++) begin
            v[i] = b[src_pos(i)];
        end
        return v;
    endfunction

endpackage

// File: rtl/lsi_sense.sv
module lsi_sense
    import lsi_pkg::*;
#(
    parameter int unsigned NC = NCOND
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] cond_in,
    output logic [NC-1:0] cond_q,
    output logic [NC-1:0] chg
);

    for (genvar g = 0; g < NC; g++) begin : g_cond
        always_ff @(posedge clk) begin
            if (rst) begin
                cond_q[g] <= 1'b0;
            end else begin
                cond_q[g] <= cond_in[g];
            end
        end
        // either direction of change qualifies
        assign chg[g] = cond_in[g] ^ cond_q[g];
    end

endmodule

// File: rtl/lsi_pend.sv
module lsi_pend
    import lsi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  logic     clr,
    output src_vec_t pend
);

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
            end else if (set_vec[g]) begin
                pend[g] <= 1'b1;      // a new set wins over a coincident read
            end else if (clr) begin
                pend[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lsi_regs.sv
module lsi_regs
    import lsi_pkg::*;
#(
    parameter int unsigned ADDR_W    = 1,
    parameter int unsigned STAT_ADDR = 0,
    parameter int unsigned MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  byte_t             wdata,
    input  src_vec_t          status,
    output byte_t             rdata,
    output src_vec_t          mask,
    output acc_t              acc
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    always_comb begin
        acc.stat_rd = rd && (addr == A_STAT);
        acc.mask_rd = rd && (addr == A_MASK);
        acc.mask_wr = wr && (addr == A_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (acc.mask_wr) begin
            mask <= pick(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.stat_rd) begin
            rdata = place(status);
        end else if (acc.mask_rd) begin
            rdata = place(mask);
        end
    end

endmodule

// File: rtl/line_stat_irq.sv
module line_stat_irq
    import lsi_pkg::*;
#(
    parameter int unsigned ADDR_W    = 1,
    parameter int unsigned STAT_ADDR = 0,
    parameter int unsigned MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_det,
    input  logic              ilim_det,
    input  logic              trip_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NCOND-1:0] cond_q;
    logic [NCOND-1:0] cond_chg;
    src_vec_t         set_vec;
    src_vec_t         pend_q;
    src_vec_t         mask_q;
    src_vec_t         status;
    acc_t             acc;

    lsi_sense #(.NC(NCOND)) u_sense (
        .clk     (clk),
        .rst     (rst),
        .cond_in ({ilim_det, open_det}),
        .cond_q  (cond_q),
        .chg     (cond_chg)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_OPEN] = cond_chg[SRC_OPEN];
        set_vec[SRC_ILIM] = cond_chg[SRC_ILIM];
        set_vec[SRC_TRIP] = trip_evt;
    end

    lsi_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (acc.stat_rd),
        .pend    (pend_q)
    );

    // live levels for the conditions, sticky latch for the trip event
    always_comb begin
        status           = '0;
        status[SRC_OPEN] = cond_q[SRC_OPEN];
        status[SRC_ILIM] = cond_q[SRC_ILIM];
        status[SRC_TRIP] = pend_q[SRC_TRIP];
    end

    lsi_regs #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wdata  (bus_wdata),
        .status (status),
        .rdata  (bus_rdata),
        .mask   (mask_q),
        .acc    (acc)
    );

    assign irq = |(pend_q & mask_q);

endmodule

// File: rtl/line_stat_irq_chk.sv
module line_stat_irq_chk
    import lsi_pkg::*;
#(
    parameter int unsigned ADDR_W    = 1,
    parameter int unsigned STAT_ADDR = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              open_det,
    input logic              ilim_det,
    input logic              trip_evt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input src_vec_t          pend,
    input src_vec_t          mask
);

    logic prev_open;
    logic prev_ilim;
    logic stat_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_open <= 1'b0;
            prev_ilim <= 1'b0;
        end else begin
            prev_open <= open_det;
            prev_ilim <= ilim_det;
        end
    end

    assign stat_acc = (bus_addr == ADDR_W'(STAT_ADDR));

    a_r2_status_live: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && stat_acc) |-> (bus_rdata[1] == prev_open && bus_rdata[2] == prev_ilim));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> ((bus_rdata & ~place('1)) == '0));

    a_r3_stat_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && stat_acc) |=> $stable(mask));

    a_r4_open_rise: assert property (@(posedge clk) disable iff (rst)
        (open_det && !prev_open) |=> pend[SRC_OPEN]);

    a_r4_ilim_rise: assert property (@(posedge clk) disable iff (rst)
        (ilim_det && !prev_ilim) |=> pend[SRC_ILIM]);

    a_r5_open_fall: assert property (@(posedge clk) disable iff (rst)
        (!open_det && prev_open) |=> pend[SRC_OPEN]);

    a_r5_ilim_fall: assert property (@(posedge clk) disable iff (rst)
        (!ilim_det && prev_ilim) |=> pend[SRC_ILIM]);

    a_r6_trip_latch: assert property (@(posedge clk) disable iff (rst)
        trip_evt |=> pend[SRC_TRIP]);

    a_r6_trip_hold: assert property (@(posedge clk) disable iff (rst)
        (pend[SRC_TRIP] && !(bus_rd && stat_acc)) |=> pend[SRC_TRIP]);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && stat_acc && !trip_evt && open_det == prev_open && ilim_det == prev_ilim)
        |=> (pend == '0));

    a_r8_coincide_kept: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && stat_acc && trip_evt) |=> pend[SRC_TRIP]);

    a_r9_no_pend_no_irq: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq);

    a_r9_all_masked: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    a_r10_mask_rd_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !stat_acc && pend[SRC_TRIP]) |=> pend[SRC_TRIP]);

endmodule

bind line_stat_irq line_stat_irq_chk #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .open_det  (open_det),
    .ilim_det  (ilim_det),
    .trip_evt  (trip_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend      (pend_q),
    .mask      (mask_q)
);

// File: tb/line_stat_irq_test.sv
module line_stat_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam logic A_STAT = 1'b0;
    localparam logic A_MASK = 1'b1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       open_det = 1'b0;
    logic       ilim_det = 1'b0;
    logic       trip_evt = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    line_stat_irq uut (
        .clk       (clk),
        .rst       (rst),
        .open_det  (open_det),
        .ilim_det  (ilim_det),
        .trip_evt  (trip_evt),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(irq === exp, tag, int'(irq), int'(exp));
    endtask

    // driver: push the expected read value, then issue the read for one cycle
    task automatic rd_reg(input logic a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        step();
        bus_rd   = 1'b0;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    // monitor: compare read data mid-cycle, before the read edge clears anything
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && bus_rd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected read", int'(bus_rdata), 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_rdata === e, t, int'(bus_rdata), int'(e));
                end
            end
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        report();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd_reg(A_STAT, 8'h00, "R1 status after reset");
        rd_reg(A_MASK, 8'h00, "R1 mask after reset");

        // R9 pending while masked, raised by a later unmask
        open_det = 1'b1;
        step();
        chk_irq(1'b0, "R9 masked edge gives no irq");
        wr_reg(A_MASK, 8'h02);
        chk_irq(1'b1, "R9 unmask raises pending irq");
        rd_reg(A_STAT, 8'h02, "R2 open level on bit 1");
        chk_irq(1'b0, "R7 status read clears");

        // R3 mask layout and status writes ignored
        wr_reg(A_MASK, 8'hFF);
        rd_reg(A_MASK, 8'h16, "R3 mask keeps bits 1 2 4");
        wr_reg(A_STAT, 8'h00);
        rd_reg(A_MASK, 8'h16, "R3 status write leaves mask");

        // R5 falling edge
        open_det = 1'b0;
        step();
        chk_irq(1'b1, "R5 falling edge irq");
        rd_reg(A_STAT, 8'h00, "R2 status after fall");
        chk_irq(1'b0, "R7 clear after fall");

        // R4 rising edge, R10 mask read keeps pending
        ilim_det = 1'b1;
        step();
        chk_irq(1'b1, "R4 rising edge irq");
        rd_reg(A_MASK, 8'h16, "R10 mask read value");
        chk_irq(1'b1, "R10 mask read keeps irq");
        rd_reg(A_STAT, 8'h04, "R2 ilim level on bit 2");
        chk_irq(1'b0, "R7 clear after ilim");

        // R6 trip latch and clear on read
        trip_evt = 1'b1;
        step();
        trip_evt = 1'b0;
        chk_irq(1'b1, "R6 trip irq");
        rd_reg(A_STAT, 8'h14, "R6 trip latched on bit 4");
        rd_reg(A_STAT, 8'h04, "R6 trip cleared by read");
        chk_irq(1'b0, "R6 irq low after clear");

        // R8 event coincident with a status read
        trip_evt = 1'b1;
        rd_reg(A_STAT, 8'h04, "R8 read in trip cycle");
        trip_evt = 1'b0;
        chk_irq(1'b1, "R8 coincident trip kept");
        rd_reg(A_STAT, 8'h14, "R8 trip bit after read");
        chk_irq(1'b0, "R8 cleared by next read");

        // both conditions change together
        open_det = 1'b1;
        ilim_det = 1'b0;
        step();
        chk_irq(1'b1, "R4 R5 simultaneous edges");
        rd_reg(A_STAT, 8'h02, "R2 status after swap");
        chk_irq(1'b0, "R7 clear after swap");

        // R4 steady level gives no new interrupt
        repeat (5) step();
        chk_irq(1'b0, "R4 steady level no irq");

        // R9 mask gating of a pending trip
        trip_evt = 1'b1;
        step();
        trip_evt = 1'b0;
        chk_irq(1'b1, "R9 trip irq unmasked");
        wr_reg(A_MASK, 8'h00);
        chk_irq(1'b0, "R9 mask clears irq");
        wr_reg(A_MASK, 8'h10);
        chk_irq(1'b1, "R9 trip enable restores irq");
        rd_reg(A_STAT, 8'h12, "R2 open and trip bits");
        chk_irq(1'b0, "R7 final clear");

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        report();
    end

endmodule